// File: doc/BRIEF.md
# Transmit Babble, Heartbeat and Memory-Ready Watchdog

This block watches a network transmitter and its DMA memory port and reports three kinds of fault as single-cycle event pulses for a status register. It counts the data bytes sent in the current frame and raises a babble event when one frame grows too long. The frame is not cut short. After each transmission ends it opens a short window in which the transceiver must return a collision test pulse; if the pulse never comes, it raises a collision-test error. It also times every DMA memory cycle and raises a memory error when the ready response comes too late. A memory error also asks the receiver and transmitter to shut down.

Both timeouts are computed at elaboration from the clock-frequency parameter, rounded up to whole cycles. The default clock of 100 MHz gives 200 cycles for the 2 us heartbeat window and 2560 cycles for the 25.6 us memory-ready limit. A stop input holds the whole monitor cleared. Frame formatting and the memory bus protocol are handled elsewhere.

Top module: `tx_dma_watchdog`

## Requirements
- R1: After reset is released, babble_o, cerr_o, merr_o and shutdown_o are all low and no count or window is in progress.
- R2: babble_o pulses in the cycle after the edge that samples the 1519th byte_sent_i strobe of a frame. A strobe in the same cycle as frame_start_i counts as the first byte of the new frame.
- R3: babble_o pulses at most once per frame. Bytes beyond the limit raise no further babble, and a babble event never drives shutdown_o.
- R4: frame_start_i restarts the byte count from zero, so bytes from earlier frames never add to the count of a later frame.
- R5: If no collision_i is sampled, cerr_o pulses once, HB_CYC edges after the edge that sampled frame_end_i (HB_CYC = 200 at 100 MHz).
- R6: A collision_i sampled on any of the HB_CYC edges after the frame_end_i edge closes the window, and no cerr_o follows.
- R7: A new frame_end_i during an open heartbeat window restarts that window from the new edge.
- R8: If mem_ready_i is not sampled, merr_o pulses once, MEM_CYC edges after the edge that sampled dma_start_i (MEM_CYC = 2560 at 100 MHz).
- R9: A mem_ready_i sampled on any of the MEM_CYC edges after the dma_start_i edge ends the timing, and no merr_o follows.
- R10: shutdown_o pulses in exactly the same cycle as merr_o and at no other time.
- R11: While stop_i is high, every output is low and no event can be started. A count or window in progress when stop_i rises is discarded.
- R12: Every event output is high for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Holds the monitor cleared while high |
| byte_sent_i | input | 1 | One data byte of the current frame was sent |
| frame_start_i | input | 1 | A new transmit frame begins |
| frame_end_i | input | 1 | The current transmission has completed |
| collision_i | input | 1 | Collision input from the transceiver |
| dma_start_i | input | 1 | A DMA memory cycle begins |
| mem_ready_i | input | 1 | Memory ready response |
| babble_o | output | 1 | Babble event pulse |
| cerr_o | output | 1 | Missing collision test pulse event |
| merr_o | output | 1 | Memory-ready timeout event |
| shutdown_o | output | 1 | Request to turn the receiver and transmitter off |

## Verification
The assertions check on every cycle that each event pulse lasts one cycle and that a babble pulse always follows a sampled byte strobe. They also check that a window never expires on an edge that sampled its cancelling input, and that nothing is reported in the cycle after a stop clear. Only the bench scenarios can show the exact latencies: the 1519-byte limit, the 200-cycle and 2560-cycle windows, and collision or ready arriving on the last allowed edge. The same applies to the restart on a repeated frame end, the count reset at frame start, and the effect of stop on a count or window that is already running.

// File: rtl/tx_wd_pkg.sv
package tx_wd_pkg;
  // Round up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    longint unsigned prod;
    prod = clk_hz * ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/tx_wd_byte_limit.sv
module tx_wd_byte_limit #(
  parameter int unsigned LIMIT = 1519
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic frame_start_i,
  input  logic byte_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, base, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    base   = frame_start_i ? '0 : cnt_q;
    cnt_d  = base;
    flag_d = 1'b0;
    // saturate at the limit so the flag fires once per frame
    if (byte_i && base != LIM) begin
      cnt_d  = base + CW'(1);
      flag_d = (cnt_d == LIM);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  a_r2_flag_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> $past(byte_i));
  a_r12_flag_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> !flag_q);
  a_r11_flag_quiet_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> !flag_q);
endmodule

// File: rtl/tx_wd_window.sv
module tx_wd_window #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic arm_i,
  input  logic hit_i,
  output logic expire_o
);
  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic          active_q;
  logic [TW-1:0] tmr_q;
  logic          expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tmr_q    <= '0;
      expire_q <= 1'b0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      tmr_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (arm_i) begin
        // arming (re)starts the window; hit in the arming cycle is ignored
        active_q <= 1'b1;
        tmr_q    <= '0;
      end else if (active_q) begin
        if (hit_i) begin
          active_q <= 1'b0;
        end else if (tmr_q == LAST) begin
          active_q <= 1'b0;
          expire_q <= 1'b1;
        end else begin
          tmr_q <= tmr_q + TW'(1);
        end
      end
    end
  end

  assign expire_o = expire_q;

  a_r6_no_expire_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> $past(!hit_i && !arm_i && active_q));
  a_r12_expire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |=> !expire_q);
  a_r11_quiet_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (!expire_q && !active_q));
endmodule

// File: rtl/tx_dma_watchdog.sv
module tx_dma_watchdog #(
  parameter longint unsigned CLK_FREQ_HZ  = 100_000_000,
  parameter int unsigned     BABBLE_BYTES = 1519,
  parameter int unsigned     HB_NS        = 2_000,
  parameter int unsigned     MEM_NS       = 25_600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic byte_sent_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic collision_i,
  input  logic dma_start_i,
  input  logic mem_ready_i,
  output logic babble_o,
  output logic cerr_o,
  output logic merr_o,
  output logic shutdown_o
);
  localparam int unsigned HB_CYC  = tx_wd_pkg::ns_to_cycles(CLK_FREQ_HZ, longint'(HB_NS));
  localparam int unsigned MEM_CYC = tx_wd_pkg::ns_to_cycles(CLK_FREQ_HZ, longint'(MEM_NS));

  logic babble_ev, cerr_ev, merr_ev;

  tx_wd_byte_limit #(.LIMIT(BABBLE_BYTES)) i_babble (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (stop_i),
    .frame_start_i(frame_start_i),
    .byte_i       (byte_sent_i),
    .flag_o       (babble_ev)
  );

  tx_wd_window #(.LIMIT(HB_CYC)) i_heartbeat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (stop_i),
    .arm_i   (frame_end_i),
    .hit_i   (collision_i),
    .expire_o(cerr_ev)
  );

  tx_wd_window #(.LIMIT(MEM_CYC)) i_mem_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (stop_i),
    .arm_i   (dma_start_i),
    .hit_i   (mem_ready_i),
    .expire_o(merr_ev)
  );

  // outputs are masked while stop is held
  assign babble_o   = babble_ev & ~stop_i;
  assign cerr_o     = cerr_ev   & ~stop_i;
  assign merr_o     = merr_ev   & ~stop_i;
  assign shutdown_o = merr_ev   & ~stop_i;

  a_r3_babble_no_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (babble_o && !merr_o) |-> !shutdown_o);
  a_r8_merr_needs_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merr_o |-> $past(!mem_ready_i));
  a_r5_cerr_needs_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cerr_o |-> $past(!collision_i));
endmodule

// File: tb/test_tx_dma_watchdog.sv
module test_tx_dma_watchdog;
  localparam int HB  = 200;
  localparam int MEM = 2560;
  localparam int BAB = 1519;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop = 0, byte_s = 0, fstart = 0, fend = 0, coll = 0, dma = 0, rdy = 0;
  logic babble, cerr, merr, shut;
  int n_chk = 0, n_fail = 0;
  int bab_cnt = 0, cerr_cnt = 0, merr_cnt = 0, shut_cnt = 0, mismatch = 0;

  always #5 clk = ~clk;

  tx_dma_watchdog i_tx_dma_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .byte_sent_i(byte_s),
    .frame_start_i(fstart), .frame_end_i(fend), .collision_i(coll),
    .dma_start_i(dma), .mem_ready_i(rdy),
    .babble_o(babble), .cerr_o(cerr), .merr_o(merr), .shutdown_o(shut)
  );

  always @(posedge clk) begin
    if (babble) bab_cnt++;
    if (cerr) cerr_cnt++;
    if (merr) merr_cnt++;
    if (shut) shut_cnt++;
    if (shut != merr) mismatch++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_counts();
    bab_cnt = 0; cerr_cnt = 0; merr_cnt = 0; shut_cnt = 0;
  endtask

  task automatic frame_begin();
    @(negedge clk); fstart = 1;
    @(negedge clk); fstart = 0;
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_s = 1;
    end
    @(negedge clk); byte_s = 0;
  endtask

  // pulse trig (0 frame_end, 1 dma_start), optional hit at edge index hit_at (0 = none),
  // returns first negedge index at which the output was high and the high-cycle count
  task automatic run_window(input int sel, input int hit_at, input int maxc,
                            output int first, output int highs);
    first = 0; highs = 0;
    @(negedge clk);
    if (sel == 0) fend = 1; else dma = 1;
    @(negedge clk);
    fend = 0; dma = 0;
    for (int k = 1; k <= maxc; k++) begin
      if (k == hit_at) begin
        if (sel == 0) coll = 1; else rdy = 1;
      end
      @(negedge clk);
      coll = 0; rdy = 0;
      if ((sel == 0) ? cerr : merr) begin
        highs++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic t_reset();
    chk(!babble && !cerr && !merr && !shut, "R1 outputs low after reset",
        {babble, cerr, merr, shut}, 0);
  endtask

  task automatic t_babble();
    int f, h;
    clr_counts();
    frame_begin();
    send_bytes(BAB - 1);
    cyc(2);
    chk(bab_cnt == 0, "R2 no babble at 1518 bytes", bab_cnt, 0);
    send_bytes(1);
    cyc(2);
    chk(bab_cnt == 1, "R2 babble at byte 1519", bab_cnt, 1);
    send_bytes(300);
    cyc(2);
    chk(bab_cnt == 1, "R3 single babble per frame", bab_cnt, 1);
    chk(shut_cnt == 0, "R3 babble gives no shutdown", shut_cnt, 0);
    // frame start with byte in same cycle counts as first byte
    @(negedge clk); fstart = 1; byte_s = 1;
    @(negedge clk); fstart = 0;
    send_bytes(BAB - 2);
    cyc(2);
    chk(bab_cnt == 2, "R2 frame-start byte counted", bab_cnt, 2);
    f = 0; h = 0;
  endtask

  task automatic t_frame_reset();
    clr_counts();
    frame_begin();
    send_bytes(1000);
    frame_begin();
    send_bytes(1000);
    cyc(2);
    chk(bab_cnt == 0, "R4 count restarts at frame start", bab_cnt, 0);
    send_bytes(BAB - 1000);
    cyc(2);
    chk(bab_cnt == 1, "R4 new frame reaches limit alone", bab_cnt, 1);
  endtask

  task automatic t_heartbeat();
    int f, h;
    clr_counts();
    run_window(0, 0, HB + 5, f, h);
    chk(f == HB, "R5 cerr latency", f, HB);
    chk(h == 1, "R12 cerr one cycle", h, 1);
    run_window(0, HB, HB + 5, f, h);
    chk(h == 0, "R6 collision on last edge", h, 0);
    run_window(0, 1, HB + 5, f, h);
    chk(h == 0, "R6 collision on first edge", h, 0);
    // restart: second frame_end 50 cycles in
    @(negedge clk); fend = 1;
    @(negedge clk); fend = 0;
    cyc(49);
    run_window(0, 0, HB + 5, f, h);
    chk(f == HB && h == 1, "R7 window restarts", f, HB);
    chk(merr_cnt == 0, "R5 no merr from heartbeat", merr_cnt, 0);
  endtask

  task automatic t_mem();
    int f, h;
    clr_counts();
    run_window(1, 0, MEM + 5, f, h);
    chk(f == MEM, "R8 merr latency", f, MEM);
    chk(h == 1, "R12 merr one cycle", h, 1);
    chk(shut_cnt == 1 && mismatch == 0, "R10 shutdown with merr", shut_cnt, 1);
    run_window(1, MEM, MEM + 5, f, h);
    chk(h == 0, "R9 ready on last edge", h, 0);
    run_window(1, 3, MEM + 5, f, h);
    chk(h == 0, "R9 early ready", h, 0);
    chk(shut_cnt == 1 && mismatch == 0, "R10 no extra shutdown", shut_cnt, 1);
  endtask

  task automatic t_stop();
    int f, h;
    clr_counts();
    @(negedge clk); fend = 1; dma = 1;
    @(negedge clk); fend = 0; dma = 0;
    cyc(50);
    stop = 1;
    cyc(3);
    chk(!babble && !cerr && !merr && !shut, "R11 outputs low in stop",
        {babble, cerr, merr, shut}, 0);
    fend = 1; dma = 1; byte_s = 1;
    cyc(2);
    fend = 0; dma = 0; byte_s = 0;
    cyc(MEM + 10);
    chk(cerr_cnt == 0 && merr_cnt == 0 && bab_cnt == 0, "R11 nothing during stop",
        cerr_cnt + merr_cnt + bab_cnt, 0);
    stop = 0;
    cyc(MEM + 10);
    chk(cerr_cnt == 0 && merr_cnt == 0, "R11 windows discarded", cerr_cnt + merr_cnt, 0);
    // byte count discarded by stop
    frame_begin();
    send_bytes(1000);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    send_bytes(600);
    cyc(2);
    chk(bab_cnt == 0, "R11 count cleared", bab_cnt, 0);
    send_bytes(BAB - 600);
    cyc(2);
    chk(bab_cnt == 1, "R11 count from zero after stop", bab_cnt, 1);
    f = 0; h = 0;
  endtask

  initial begin
    #(200_000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_babble();
    t_frame_reset();
    t_heartbeat();
    t_mem();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule